// File: doc/BRIEF.md
# Multi-Input Edge Wake-Up Unit

This unit watches sixteen asynchronous input lines. Each line first passes through a two-flop synchroniser. A per-channel state machine then looks for the edge direction that software selected for that line. When that edge arrives, the channel latches a pending flag. The flag stays set until software clears it by writing a one to its bit. An edge that arrives in the same cycle as a clear wins, so no event is lost.

Each channel carries a 2-bit group number. Each of the four interrupt outputs is the OR of the pending channels that are enabled and assigned to that group. The outputs are therefore level signals that a level-sensitive interrupt controller can service. The wake-up request is the OR of all enabled pending flags and is used to leave halt, idle or power-save modes.

Changing a channel's polarity would otherwise look like an edge. To prevent this, the channel enters a quiet state for one cycle, and edges seen in that cycle are dropped.

Top module: `edge_wake_unit`

Channel state machine (state = {pending, quiet}):
- Encodings: CH_IDLE = 00, CH_QUIET = 01, CH_PEND = 10, CH_PEND_QUIET = 11.
- Transition T_DETECT: in CH_IDLE, a valid edge moves the channel to CH_PEND. If the polarity changes in the same cycle, it moves to CH_PEND_QUIET instead.
- Transition T_BLANK: a change of the channel's polarity bit moves the channel to the quiet variant of its state.
- Transition T_REARM: when there is no further polarity change, CH_QUIET returns to CH_IDLE and CH_PEND_QUIET returns to CH_PEND.
- Transition T_CLEAR: a write-one-to-clear returns a pending state to CH_IDLE, or to CH_QUIET if the polarity also changes. In CH_PEND the clear only takes effect when no valid edge is present.
- Transition T_KEEP: otherwise the pending states hold.

## Requirements
- R1: After reset, every register reads 0, no flag is pending, all irq_out bits are 0 and wake_req is 0.
- R2: Register map:
  - Address 0 is the enable register, with bit k for channel k.
  - Address 1 is the polarity register, with bit k for channel k.
  - Address 2 reads the pending flags.
  - Address 3 holds the group numbers of channels 0 to 7, and address 4 those of channels 8 to 15. Channel k uses bits [2*(k%8)+1 : 2*(k%8)].
  - Every written value reads back unchanged.
- R3: A polarity bit of 0 selects rising edges and 1 selects falling edges. A selected edge on line_in[k] sets pending bit k, which becomes visible after the third rising clock edge following the input change.
- R4: A pending flag stays set until a write to address 2 has a one in its bit position. Zeros written to address 2 change nothing.
- R5: If a selected edge is detected in the same cycle as a clear of its channel, the pending flag stays set.
- R6: irq_out[g] is 1 exactly when some channel is pending, enabled and has group number g. It stays 1 until that condition ends.
- R7: A disabled channel still latches its pending flag but drives neither irq_out nor wake_req. Enabling it later asserts its output at once.
- R8: wake_req is 1 exactly when at least one enabled channel is pending.
- R9: Changing a channel's polarity bit never sets its pending flag. An edge in the cycle right after the polarity write is ignored.
- R10: An edge of the direction opposite to the selected one does not set the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 16 | Asynchronous wake-up lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for both reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_out | output | 4 | Level interrupt outputs, one per group |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench times an edge so that it reaches the detector in exactly the cycle of a write-one-to-clear. A design that lets the clear win would lose that event and read the flag as 0. It flips polarity while the line sits at a level that now counts as active. A design without the quiet cycle would report a spurious pending flag there. It also drives opposite-direction edges, partial clears that write zeros, and disabled channels. A design that decoded edges by level, cleared on zeros, or gated latching by enable instead of gating the outputs would show wrong pending or irq values. Finally, it spreads channels over different group numbers to catch a misplaced group field.

// File: rtl/ewu_pkg.sv
package ewu_pkg;

    // Per-channel state: bit 1 = pending, bit 0 = quiet (edge detection off)
    typedef enum logic [1:0] {
        CH_IDLE       = 2'b00,
        CH_QUIET      = 2'b01,
        CH_PEND       = 2'b10,
        CH_PEND_QUIET = 2'b11
    } ch_state_t;

    localparam int ADDR_ENABLE   = 0;
    localparam int ADDR_POLARITY = 1;
    localparam int ADDR_PENDING  = 2;
    localparam int ADDR_GROUP0   = 3;

endpackage

// File: rtl/ewu_sync.sv
module ewu_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // First stage captures the asynchronous lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= d_async;
        end
    end

    // Remaining stages follow one after another
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= '0;
            end else begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ewu_channel.sv
module ewu_channel
    import ewu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,     // synchronised line level
    input  logic pol_i,       // 0 = rising, 1 = falling
    input  logic pol_chg_i,   // polarity bit is being changed this cycle
    input  logic clr_i,       // write-one-to-clear for this channel
    output logic pending_o
);

    ch_state_t state_q, state_d;
    logic      act_now;
    logic      act_prev_q;
    logic      edge_hit;
    logic      quiet;

    // "Active" level folds polarity in, so one rising detector serves both
    assign act_now  = level_i ^ pol_i;
    assign edge_hit = act_now & ~act_prev_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CH_IDLE;
            act_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            act_prev_q <= act_now;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (edge_hit) begin
                    state_d = pol_chg_i ? CH_PEND_QUIET : CH_PEND;   // T_DETECT
                end else if (pol_chg_i) begin
                    state_d = CH_QUIET;                              // T_BLANK
                end
            end
            CH_QUIET: begin
                if (!pol_chg_i) begin
                    state_d = CH_IDLE;                               // T_REARM
                end
            end
            CH_PEND: begin
                if (clr_i && !edge_hit) begin
                    state_d = pol_chg_i ? CH_QUIET : CH_IDLE;        // T_CLEAR
                end else if (pol_chg_i) begin
                    state_d = CH_PEND_QUIET;                         // T_BLANK
                end
            end
            CH_PEND_QUIET: begin
                if (clr_i) begin
                    state_d = pol_chg_i ? CH_QUIET : CH_IDLE;        // T_CLEAR
                end else if (!pol_chg_i) begin
                    state_d = CH_PEND;                               // T_REARM
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pending_o = (state_q == CH_PEND) || (state_q == CH_PEND_QUIET);
        quiet     = (state_q == CH_QUIET) || (state_q == CH_PEND_QUIET);
    end

    AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && !quiet) |=> pending_o);                          // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !clr_i) |=> pending_o);                         // R4

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && clr_i && edge_hit && !quiet) |=> pending_o);    // R5

    AST_QUIET_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_QUIET) |=> !pending_o);                        // R9

endmodule

// File: rtl/ewu_regs.sv
module ewu_regs
    import ewu_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NOUT = 4,
    parameter int AW   = 3,
    parameter int DW   = 16,
    localparam int GW  = $clog2(NOUT),
    localparam int CPW = DW / GW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic [NCH-1:0]          pending_i,
    output logic [NCH-1:0]          enable_o,
    output logic [NCH-1:0]          polarity_o,
    output logic [NCH-1:0][GW-1:0]  group_o,
    output logic [NCH-1:0]          pol_chg_o,
    output logic [NCH-1:0]          clr_o
);

    logic [NCH-1:0]         en_q;
    logic [NCH-1:0]         pol_q;
    logic [NCH-1:0][GW-1:0] grp_q;
    int                     addr_i;

    assign addr_i = int'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
            grp_q <= '0;
        end else if (bus_wr) begin
            if (addr_i == ADDR_ENABLE) begin
                en_q <= bus_wdata[NCH-1:0];
            end
            if (addr_i == ADDR_POLARITY) begin
                pol_q <= bus_wdata[NCH-1:0];
            end
            for (int k = 0; k < NCH; k++) begin
                if (addr_i == ADDR_GROUP0 + k / CPW) begin
                    grp_q[k] <= bus_wdata[(k % CPW) * GW +: GW];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_i == ADDR_ENABLE) begin
            bus_rdata[NCH-1:0] = en_q;
        end else if (addr_i == ADDR_POLARITY) begin
            bus_rdata[NCH-1:0] = pol_q;
        end else if (addr_i == ADDR_PENDING) begin
            bus_rdata[NCH-1:0] = pending_i;
        end else begin
            for (int k = 0; k < NCH; k++) begin
                if (addr_i == ADDR_GROUP0 + k / CPW) begin
                    bus_rdata[(k % CPW) * GW +: GW] = grp_q[k];
                end
            end
        end
    end

    // Only channels whose polarity bit really changes are blanked
    assign pol_chg_o = (bus_wr && addr_i == ADDR_POLARITY) ?
                       (bus_wdata[NCH-1:0] ^ pol_q) : '0;
    assign clr_o     = (bus_wr && addr_i == ADDR_PENDING) ?
                       bus_wdata[NCH-1:0] : '0;

    assign enable_o   = en_q;
    assign polarity_o = pol_q;
    assign group_o    = grp_q;

    AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> bus_wr);                                          // R4

    AST_POL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && addr_i == ADDR_POLARITY) |=>
        (polarity_o == $past(bus_wdata[NCH-1:0])));                   // R2

endmodule

// File: rtl/ewu_combine.sv
module ewu_combine #(
    parameter int NCH  = 16,
    parameter int NOUT = 4,
    localparam int GW  = $clog2(NOUT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          pending_i,
    input  logic [NCH-1:0]          enable_i,
    input  logic [NCH-1:0][GW-1:0]  group_i,
    output logic [NOUT-1:0]         irq_o,
    output logic                    wake_o
);

    logic [NCH-1:0] live;

    assign live   = pending_i & enable_i;
    assign wake_o = |live;

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        always_comb begin
            irq_o[g] = 1'b0;
            for (int k = 0; k < NCH; k++) begin
                if (live[k] && int'(group_i[k]) == g) begin
                    irq_o[g] = 1'b1;
                end
            end
        end
    end

    AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> wake_o);                                          // R8

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i == '0) |-> (irq_o == '0 && !wake_o));                // R7

endmodule

// File: rtl/edge_wake_unit.sv
module edge_wake_unit
    import ewu_pkg::*;
#(
    parameter int NCH         = 16,
    parameter int NOUT        = 4,
    parameter int AW          = 3,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2,
    localparam int GW         = $clog2(NOUT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  line_in,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [NOUT-1:0] irq_out,
    output logic            wake_req
);

    logic [NCH-1:0]         line_s;
    logic [NCH-1:0]         pend;
    logic [NCH-1:0]         en;
    logic [NCH-1:0]         pol;
    logic [NCH-1:0][GW-1:0] grp;
    logic [NCH-1:0]         pol_chg;
    logic [NCH-1:0]         clr;

    ewu_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_in),
        .q_sync  (line_s)
    );

    ewu_regs #(.NCH(NCH), .NOUT(NOUT), .AW(AW), .DW(DW)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pending_i  (pend),
        .enable_o   (en),
        .polarity_o (pol),
        .group_o    (grp),
        .pol_chg_o  (pol_chg),
        .clr_o      (clr)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        ewu_channel i_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_i   (line_s[k]),
            .pol_i     (pol[k]),
            .pol_chg_i (pol_chg[k]),
            .clr_i     (clr[k]),
            .pending_o (pend[k])
        );
    end

    ewu_combine #(.NCH(NCH), .NOUT(NOUT)) i_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pend),
        .enable_i  (en),
        .group_i   (grp),
        .irq_o     (irq_out),
        .wake_o    (wake_req)
    );

endmodule

// File: tb/test_edge_wake_unit.sv
module test_edge_wake_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] line_in = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq_out;
    logic        wake_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    edge_wake_unit i_edge_wake_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .wake_req  (wake_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 3'(a);
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        d = bus_rdata;
    endtask

    // Change a line, then wait until the third rising edge has passed
    task automatic set_line(input int ch, input logic v);
        @(negedge clk);
        line_in[ch] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(a, d);
            check("R1", "register after reset", d, 0);
        end
        check("R1", "irq after reset", irq_out, 0);
        check("R1", "wake after reset", wake_req, 0);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(0, 16'hA5C3);
        rd(0, d);  check("R2", "enable readback", d, 16'hA5C3);
        wr(1, 16'h0F0F);
        rd(1, d);  check("R2", "polarity readback", d, 16'h0F0F);
        wr(1, 16'h0000);
        rd(2, d);  check("R9", "no pending from polarity writes", d, 0);
        wr(3, 16'h1B2D);
        rd(3, d);  check("R2", "group low readback", d, 16'h1B2D);
        wr(4, 16'hE471);
        rd(4, d);  check("R2", "group high readback", d, 16'hE471);
        wr(0, 16'h0000);
        wr(3, 16'h0000);
        wr(4, 16'h0000);
    endtask

    task automatic t_rise();
        logic [15:0] d;
        set_line(4, 1'b1);
        rd(2, d);  check("R3", "rising edge sets pending ch4", d, 16'h0010);
        wr(2, 16'hFFEF);
        rd(2, d);  check("R4", "zero in clear keeps ch4", d, 16'h0010);
        wr(2, 16'h0010);
        rd(2, d);  check("R4", "one clears ch4", d, 0);
        set_line(4, 1'b0);
        rd(2, d);  check("R10", "falling edge ignored on rising ch4", d, 0);
    endtask

    task automatic t_fall();
        logic [15:0] d;
        wr(1, 16'h0800);
        set_line(11, 1'b1);
        rd(2, d);  check("R10", "rising edge ignored on falling ch11", d, 0);
        set_line(11, 1'b0);
        rd(2, d);  check("R3", "falling edge sets pending ch11", d, 16'h0800);
        wr(2, 16'hFFFF);
        wr(1, 16'h0000);
        rd(2, d);  check("R4", "cleared after ch11", d, 0);
    endtask

    task automatic t_collide();
        logic [15:0] d;
        set_line(2, 1'b1);
        rd(2, d);  check("R3", "ch2 pending before collision", d, 16'h0004);
        set_line(2, 1'b0);
        // new rising edge reaches the detector in the cycle of the clear
        @(negedge clk); line_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 16'h0004;
        @(negedge clk); bus_wr = 1'b0;
        rd(2, d);  check("R5", "edge wins over same-cycle clear", d, 16'h0004);
        wr(2, 16'h0004);
        rd(2, d);  check("R4", "plain clear afterwards", d, 0);
        set_line(2, 1'b0);
    endtask

    task automatic t_group();
        logic [15:0] d;
        wr(0, 16'h0281);          // channels 0, 7, 9
        wr(3, 16'hC000);          // ch7 -> group 3, ch0 -> group 0
        wr(4, 16'h0008);          // ch9 -> group 2
        set_line(7, 1'b1);
        check("R6", "ch7 drives irq3", irq_out, 4'b1000);
        check("R8", "wake with ch7", wake_req, 1);
        repeat (4) @(negedge clk);
        check("R6", "irq3 level holds", irq_out, 4'b1000);
        set_line(9, 1'b1);
        check("R6", "ch9 adds irq2", irq_out, 4'b1100);
        wr(2, 16'h0080);
        @(negedge clk);
        check("R6", "clear ch7 drops irq3", irq_out, 4'b0100);
        set_line(0, 1'b1);
        check("R6", "ch0 adds irq0", irq_out, 4'b0101);
        wr(2, 16'hFFFF);
        @(negedge clk);
        check("R6", "all cleared irq", irq_out, 0);
        check("R8", "all cleared wake", wake_req, 0);
        set_line(0, 1'b0);
        set_line(7, 1'b0);
        set_line(9, 1'b0);
        rd(2, d);  check("R10", "falling edges ignored", d, 0);
        wr(0, 16'h0000);
        wr(3, 16'h0000);
        wr(4, 16'h0000);
    endtask

    task automatic t_enable();
        logic [15:0] d;
        set_line(3, 1'b1);
        rd(2, d);  check("R7", "disabled ch3 still latches", d, 16'h0008);
        check("R7", "disabled ch3 no irq", irq_out, 0);
        check("R7", "disabled ch3 no wake", wake_req, 0);
        wr(0, 16'h0008);
        @(negedge clk);
        check("R7", "enable ch3 asserts irq0", irq_out, 4'b0001);
        check("R8", "enable ch3 asserts wake", wake_req, 1);
        wr(2, 16'h0008);
        @(negedge clk);
        check("R8", "clear ch3 drops wake", wake_req, 0);
        set_line(3, 1'b0);
        wr(0, 16'h0000);
    endtask

    task automatic t_polflip();
        logic [15:0] d;
        wr(1, 16'h0020);          // ch5 falling, line low
        set_line(5, 1'b1);
        rd(2, d);  check("R10", "rising ignored on falling ch5", d, 0);
        wr(1, 16'h0000);          // line high now counts as active
        repeat (3) @(negedge clk);
        rd(2, d);  check("R9", "polarity flip gives no pending", d, 0);
        set_line(5, 1'b0);
        set_line(5, 1'b1);
        rd(2, d);  check("R3", "ch5 detects after flip", d, 16'h0020);
        wr(2, 16'hFFFF);
        set_line(5, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_rise();
        t_fall();
        t_collide();
        t_group();
        t_enable();
        t_polflip();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (R1..R10 not completed): actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule